// File: doc/BRIEF.md
# Configuration Address Translator

This block turns a local-bus access that lands in the downstream configuration window into a PCI type-0 configuration address. A 16-bit offset within the window is joined with the low half of a map-configuration register to form a 32-bit local address. The upper part of that local address is a one-hot device-select field. The block finds the lowest set bit of that field to recover the device number. It then packs the bus number, the device, the function and the dword register index into the standard configuration address, with the enable bit set.

Two kinds of access cannot be translated. When the map register marks the access as something other than type-0, the block flags it as invalid and presents all-ones read data at the access width. When the device-select field is entirely zero, it raises an error flag and issues no enabled address. Each request is answered one clock later with a single-cycle done pulse. The results stay on the outputs until the next request.

Top module: `cfg_addr_xlate`

## Requirements
- R1: Every cycle with `req_i` high is followed in the next cycle by `done_o` high for exactly that cycle; `done_o` is never high unless `req_i` was high in the cycle before.
- R2: The local address is formed with `map_cfg_i[15:0]` as bits [31:16] and `win_off_i` as bits [15:0]; `map_cfg_i[31:17]` has no effect on the result.
- R3: If `map_cfg_i[16]` is 1, the result is invalid: `invalid_o`=1, `valid_o`=0, `error_o`=0, `cfg_addr_o`=0, and `fill_o` holds ones in its low 8*(`size_i`+1) bits and zeros above them. This outcome takes priority over R7.
- R4: The device number is the index (0 to 20) of the lowest set bit of local address bits [31:11], where local bit 11 is index 0. It appears in `cfg_addr_o[15:11]`.
- R5: Local address bits [10:8] appear in `cfg_addr_o[10:8]`. Local bits [7:2] appear in `cfg_addr_o[7:2]`, and `cfg_addr_o[1:0]` is 0.
- R6: On a valid translation, `cfg_addr_o[23:16]` equals `bus_num_i`, `cfg_addr_o[31]` is 1 and `cfg_addr_o[30:24]` is 0.
- R7: If local bits [31:11] are all zero and R3 does not apply, then `error_o`=1, `valid_o`=0, `invalid_o`=0, `cfg_addr_o`=0 and `fill_o`=0.
- R8: All access sizes of 1 to 4 bytes are accepted (`size_i` = byte count minus 1). A translation that is neither invalid nor in error gives `valid_o`=1 and `fill_o`=0 for every size.
- R9: Reset clears every output to 0. Between requests, all outputs hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Translation request strobe |
| win_off_i | input | 16 | Offset of the access inside the configuration window |
| map_cfg_i | input | 32 | Map-configuration register value |
| bus_num_i | input | 8 | Bus number to place in the output address |
| size_i | input | 2 | Access size in bytes minus one |
| done_o | output | 1 | One-cycle pulse marking new results |
| cfg_addr_o | output | 32 | Translated configuration address |
| valid_o | output | 1 | Translation succeeded |
| invalid_o | output | 1 | Access is not a type-0 access |
| error_o | output | 1 | Device-select field was zero |
| fill_o | output | 32 | Read data to return for an invalid access |

## Verification
The hardest cases to reach are the device-select bits that come from the map register rather than from the offset, up to index 20 at local bit 31. These bits are only reachable through `map_cfg_i[15:0]`. The vector table sets single map bits and also patterns that combine offset bits with map bits, so that the lowest-bit search is checked at both ends and across the 16-bit seam. Further directed runs cover the case where a set bit 16 and a zero select field occur together. They also cover back-to-back requests and idle gaps in which the outputs must hold.

// File: rtl/cfg_addr_xlate.sv
module cfg_addr_xlate #(
  parameter int OFF_W     = 16,
  parameter int BUS_W     = 8,
  parameter int SZ_W      = 2,
  parameter int IDSEL_LSB = 11,
  parameter int INV_BIT   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_i,
  input  logic [15:0] win_off_i,
  input  logic [31:0] map_cfg_i,
  input  logic [7:0]  bus_num_i,
  input  logic [1:0]  size_i,
  output logic        done_o,
  output logic [31:0] cfg_addr_o,
  output logic        valid_o,
  output logic        invalid_o,
  output logic        error_o,
  output logic [31:0] fill_o
);
  localparam int LOC_W   = 32;
  localparam int HI_W    = LOC_W - OFF_W;
  localparam int IDSEL_W = LOC_W - IDSEL_LSB;
  localparam int DEV_W   = 5;

  logic [LOC_W-1:0]   loc;
  logic [IDSEL_W-1:0] idsel;
  logic [DEV_W-1:0]   dev;
  logic               bad_type, no_dev;
  logic [31:0]        addr_n, ones_n;

  assign loc      = {map_cfg_i[HI_W-1:0], win_off_i};
  assign idsel    = loc[LOC_W-1:IDSEL_LSB];
  assign bad_type = map_cfg_i[INV_BIT];
  assign no_dev   = (idsel == '0);

  // lowest set bit wins: scan downward so the last hit is the smallest index
  always_comb begin
    dev = '0;
    for (int i = IDSEL_W - 1; i >= 0; i--)
      if (idsel[i]) dev = DEV_W'(i);
  end

  assign addr_n = {1'b1, 7'd0, bus_num_i, dev, loc[10:8], loc[7:2], 2'b00};
  assign ones_n = 32'hFFFF_FFFF >> {~size_i, 3'b000};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o     <= 1'b0;
      cfg_addr_o <= '0;
      valid_o    <= 1'b0;
      invalid_o  <= 1'b0;
      error_o    <= 1'b0;
      fill_o     <= '0;
    end else begin
      done_o <= req_i;
      if (req_i) begin
        invalid_o  <= bad_type;
        error_o    <= !bad_type && no_dev;
        valid_o    <= !bad_type && !no_dev;
        cfg_addr_o <= (bad_type || no_dev) ? '0 : addr_n;
        fill_o     <= bad_type ? ones_n : '0;
      end
    end
  end

  p_done_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> done_o);
  p_done_needs_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(req_i));
  p_one_outcome_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $onehot({valid_o, invalid_o, error_o}));
  p_ones_on_invalid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && invalid_o) |-> (fill_o[7:0] == 8'hFF && cfg_addr_o == '0));
  p_enable_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && valid_o) |-> (cfg_addr_o[31] && cfg_addr_o[30:24] == '0 && cfg_addr_o[1:0] == '0));
  p_bus_field_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !bad_type && !no_dev) |=> (cfg_addr_o[23:16] == $past(bus_num_i)));
  p_err_suppress_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && error_o) |-> (cfg_addr_o == '0 && fill_o == '0));
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> ($stable(cfg_addr_o) && $stable(fill_o) && $stable({valid_o, invalid_o, error_o})));
endmodule

// File: tb/tb_cfg_addr_xlate.sv
`timescale 1ns/1ps
module tb_cfg_addr_xlate;
  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic [15:0] off = '0;
  logic [31:0] map = '0;
  logic [7:0]  bus = '0;
  logic [1:0]  sz  = '0;
  logic done, valid, invalid, error;
  logic [31:0] addr, fill;
  int applied = 0, bad = 0;

  always #4 clk = ~clk;

  cfg_addr_xlate dut (.clk(clk), .rst_n(rst_n), .req_i(req), .win_off_i(off),
    .map_cfg_i(map), .bus_num_i(bus), .size_i(sz), .done_o(done),
    .cfg_addr_o(addr), .valid_o(valid), .invalid_o(invalid), .error_o(error), .fill_o(fill));

  typedef struct packed {
    logic [15:0] off; logic [31:0] map; logic [7:0] bus; logic [1:0] sz;
    logic [31:0] addr; logic [2:0] flags;
  } vec_t;

  // flags = {valid, invalid, error}
  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{16'h0800, 32'h0000_0000, 8'h00, 2'd3, 32'h8000_0000, 3'b100},
    '{16'h0000, 32'h0000_0002, 8'h12, 2'd0, 32'h8012_3000, 3'b100},
    '{16'h1F7F, 32'h0000_0000, 8'hFF, 2'd1, 32'h80FF_077C, 3'b100},
    '{16'h3000, 32'h0000_0000, 8'h01, 2'd2, 32'h8001_0800, 3'b100},
    '{16'h0204, 32'h0000_8000, 8'h00, 2'd3, 32'h8000_A204, 3'b100},
    '{16'h00FF, 32'h0000_0040, 8'h05, 2'd0, 32'h8005_58FC, 3'b100},
    '{16'h0800, 32'h0001_0000, 8'h33, 2'd0, 32'h0000_0000, 3'b010},
    '{16'h0800, 32'h0001_0040, 8'h33, 2'd2, 32'h0000_0000, 3'b010},
    '{16'h07FF, 32'h0000_0000, 8'h44, 2'd3, 32'h0000_0000, 3'b001},
    '{16'h0000, 32'hFFFE_0000, 8'h44, 2'd1, 32'h0000_0000, 3'b001},
    '{16'h0000, 32'hFFFE_0004, 8'hAA, 2'd1, 32'h80AA_3800, 3'b100},
    '{16'hF800, 32'h0000_FFFF, 8'h3C, 2'd2, 32'h803C_0000, 3'b100}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_fill(input logic [2:0] flags, input logic [1:0] s);
    logic [31:0] m = '0;
    for (int b = 0; b < 32; b++) if (b < 8 * (int'(s) + 1)) m[b] = 1'b1;
    return flags[1] ? m : 32'h0;
  endfunction

  task automatic drive(input logic [15:0] o, input logic [31:0] m, input logic [7:0] b, input logic [1:0] s);
    @(negedge clk);
    off = o; map = m; bus = b; sz = s; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset addr", addr, 32'h0);
    check("R9 reset flags", {28'h0, done, valid, invalid, error}, 32'h0);
    check("R9 reset fill", fill, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 no done without request", {31'h0, done}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      drive(TBL[k].off, TBL[k].map, TBL[k].bus, TBL[k].sz);
      check("R1 done pulse", {31'h0, done}, 32'h1);
      check("R2 R4 R5 R6 cfg address", addr, TBL[k].addr);
      check("R3 R7 R8 outcome flags", {29'h0, valid, invalid, error}, {29'h0, TBL[k].flags});
      check("R3 R8 fill data", fill, exp_fill(TBL[k].flags, TBL[k].sz));
      @(negedge clk);
      check("R1 done single cycle", {31'h0, done}, 32'h0);
    end

    // R9: idle with changing inputs must not disturb held results (last vector 0x803C0000)
    off = 16'h0000; map = 32'h0001_0000; bus = 8'h77; sz = 2'd0;
    repeat (4) @(negedge clk);
    check("R9 hold addr", addr, 32'h803C_0000);
    check("R9 hold flags", {29'h0, valid, invalid, error}, 32'h4);
    check("R9 hold fill", fill, 32'h0);

    // R3 over R7: type bit set and zero select field -> invalid, not error
    drive(16'h0000, 32'h0001_0000, 8'h01, 2'd1);
    check("R3 priority flags", {29'h0, valid, invalid, error}, 32'h2);
    check("R3 fill two bytes", fill, 32'h0000_FFFF);

    // R2: upper map bits ignored, same result as with them clear
    drive(16'h0104, 32'hABCC_0008, 8'h09, 2'd3);
    check("R2 upper map ignored", addr, 32'h8009_4104);

    // R1: back-to-back requests, each answered in turn
    @(negedge clk);
    off = 16'h0800; map = 32'h0; bus = 8'h02; sz = 2'd3; req = 1'b1;
    @(negedge clk);
    check("R1 first of pair done", {31'h0, done}, 32'h1);
    check("R1 first of pair addr", addr, 32'h8002_0000);
    off = 16'h0000; map = 32'h0000_0010;
    @(negedge clk);
    req = 1'b0;
    check("R1 second of pair done", {31'h0, done}, 32'h1);
    check("R4 second of pair device 9", addr, 32'h8002_4800);
    @(negedge clk);
    check("R1 pair ends", {31'h0, done}, 32'h0);

    // R8: each size on a valid access keeps fill at zero
    for (int s = 0; s < 4; s++) begin
      drive(16'h2000, 32'h0, 8'h10, 2'(s));
      check("R8 size accepted", {29'h0, valid, invalid, error}, 32'h4);
      check("R8 fill zero", fill, 32'h0);
    end

    // R9: reset mid-run clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 reset clears addr", addr, 32'h0);
    check("R9 reset clears flags", {29'h0, valid, invalid, error}, 32'h0);
    summary();
  end
endmodule